// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write burst request into the ordered list of column addresses that the burst touches. A request is a start strobe with a 9-bit starting column. The two mode fields, a length code and an ordering select, are sampled with it. From that point the block presents one column per beat. The consumer steps to the next beat by raising an advance enable. A valid flag marks a live beat, and a last flag marks the final one. Reads and writes use the same sequence.

The burst stays inside an aligned block of columns whose size equals the burst length. The column bits above the in-block offset never change during a burst, and the offset wraps within the block. In sequential ordering the offset counts up from the starting offset, modulo the length. In interleaved ordering the offset is the starting offset XOR the beat index. A length code that is not defined is reported on an error flag, and that request issues no beats. An abort input ends a burst at once. A new start strobe during a burst restarts the sequence.

Top module: `burst_colgen`

## Requirements
- R1: After reset, col_valid, col_last and mode_err are all 0.
- R2: The burst length is taken from len_code at the start strobe: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats.
- R3: With order_sel = 0 (sequential), beat k has in-block offset (s + k) mod L, where s is the start offset and L the length. For example, L = 4 with s = 1 gives offsets 1,2,3,0.
- R4: With order_sel = 1 (interleaved), beat k has in-block offset s XOR k. For example, L = 8 with s = 5 gives offsets 5,4,7,6,1,0,3,2.
- R5: The column bits above the offset stay equal to those of start_col for every beat. The offset is bit 0 for length 2, bits 1..0 for length 4 and bits 2..0 for length 8.
- R6: A start strobe registered at one clock edge presents beat 0 after that edge. Each edge with col_valid and advance high moves to the next beat. Without advance, the column and col_valid hold.
- R7: col_last is 1 exactly on the final beat. An advance on the final beat drops col_valid at the next edge.
- R8: A start strobe with any other len_code (000 or 1xx) sets mode_err and issues no beats. mode_err stays set until a start strobe with a defined code clears it.
- R9: abort clears col_valid at the next edge. It takes priority over a start strobe and over advance in the same cycle.
- R10: A start strobe during a burst discards the remaining beats. The block then begins the new sequence from the new column with the new mode fields.
- R11: Changes on start_col, len_code or order_sel between start strobes have no effect on a burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst with the fields presented this cycle |
| start_col | input | COL_W (9) | Starting column of the burst |
| len_code | input | 3 | Burst length code (001=2, 010=4, 011=8, others reserved) |
| order_sel | input | 1 | Beat ordering: 0 sequential, 1 interleaved |
| advance | input | 1 | Consume the current beat and step to the next |
| abort | input | 1 | End the current burst immediately |
| col_addr | output | COL_W (9) | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | The presented beat is the final one |
| mode_err | output | 1 | The last start strobe carried a reserved length code |

## Verification
A corrupted latched start column or ordering bit shows as a wrong col_addr on the first beat after the start edge. A wrong beat count or stored length shows as a wrong offset, or as col_last or the fall of col_valid arriving on the wrong beat. Either appears within at most eight advances. Each burst is therefore compared beat by beat, including cycles where advance is held low, for every length and both orderings. Starting columns sit at block edges and at the top of the column range, so any carry out of the offset field shows in the upper bits.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam int BEAT_W = 3;
  localparam int LEN_W  = 2;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  typedef struct packed {
    logic             legal;
    logic [LEN_W-1:0] len_log2;
  } len_cfg_t;

  function automatic logic [BEAT_W-1:0] low_mask(input logic [LEN_W-1:0] lg);
    logic [BEAT_W-1:0] m;
    for (int i = 0; i < BEAT_W; i++) begin
      m[i] = (LEN_W'(i) < lg);
    end
    return m;
  endfunction

endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec
  import colgen_pkg::*;
(
  input  logic [2:0] len_code,
  output len_cfg_t   cfg
);

  always_comb begin
    cfg.legal    = 1'b1;
    cfg.len_log2 = '0;
    unique case (len_code)
      3'b001:  cfg.len_log2 = LEN_W'(1);
      3'b010:  cfg.len_log2 = LEN_W'(2);
      3'b011:  cfg.len_log2 = LEN_W'(3);
      default: cfg.legal    = 1'b0;
    endcase
  end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import colgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  len_cfg_t          cfg,
  input  logic              abort,
  input  logic              advance,
  output logic              valid,
  output logic              last,
  output logic [BEAT_W-1:0] beat,
  output logic [LEN_W-1:0]  len_log2
);

  logic              valid_q, valid_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              at_end;

  assign at_end = (beat_q == low_mask(len_q));

  always_comb begin
    valid_d = valid_q;
    beat_d  = beat_q;
    len_d   = len_q;
    if (abort) begin
      valid_d = 1'b0;
    end else if (load) begin
      valid_d = cfg.legal;
      beat_d  = '0;
      if (cfg.legal) len_d = cfg.len_log2;
    end else if (advance && valid_q) begin
      if (at_end) valid_d = 1'b0;
      else        beat_d  = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
      len_q   <= LEN_W'(1);
    end else begin
      valid_q <= valid_d;
      beat_q  <= beat_d;
      len_q   <= len_d;
    end
  end

  assign valid    = valid_q;
  assign last     = valid_q && at_end;
  assign beat     = beat_q;
  assign len_log2 = len_q;

  // R6: a beat index never exceeds the latched length
  p_beat_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ((beat_q & ~low_mask(len_q)) == '0));

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0]  base_col,
  input  logic [LEN_W-1:0]  len_log2,
  input  order_e            order,
  input  logic [BEAT_W-1:0] beat,
  output logic [COL_W-1:0]  col
);

  logic [BEAT_W-1:0] mask, start_off, off_seq, off_xor, off_sel, low_bits;

  always_comb begin
    mask      = low_mask(len_log2);
    start_off = base_col[BEAT_W-1:0] & mask;
    off_seq   = (start_off + beat) & mask;
    off_xor   = (start_off ^ beat) & mask;
    off_sel   = (order == ORD_INTLV) ? off_xor : off_seq;
    low_bits  = (base_col[BEAT_W-1:0] & ~mask) | off_sel;
  end

  generate
    if (COL_W > BEAT_W) begin : g_upper
      assign col = {base_col[COL_W-1:BEAT_W], low_bits};
    end else begin : g_narrow
      assign col = low_bits[COL_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             order_sel,
  input  logic             advance,
  input  logic             abort,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_err
);

  len_cfg_t          cfg;
  logic [COL_W-1:0]  base_q, base_d;
  order_e            order_q, order_d;
  logic              err_q, err_d;
  logic              load_en, err_en;
  logic [BEAT_W-1:0] beat;
  logic [LEN_W-1:0]  len_log2;

  colgen_len_dec u_dec (
    .len_code (len_code),
    .cfg      (cfg)
  );

  always_comb begin
    load_en = start && !abort && cfg.legal;
    base_d  = start_col;
    order_d = order_e'(order_sel);
    err_en  = start;
    err_d   = !cfg.legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_SEQ;
      err_q   <= 1'b0;
    end else begin
      if (load_en) begin
        base_q  <= base_d;
        order_q <= order_d;
      end
      if (err_en) err_q <= err_d;
    end
  end

  colgen_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .cfg      (cfg),
    .abort    (abort),
    .advance  (advance),
    .valid    (col_valid),
    .last     (col_last),
    .beat     (beat),
    .len_log2 (len_log2)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base_col (base_q),
    .len_log2 (len_log2),
    .order    (order_q),
    .beat     (beat),
    .col      (col_addr)
  );

  assign mode_err = err_q;

  p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_last && advance && !start && !abort) |=> !col_valid);

  p_abort_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !col_valid);

  p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !cfg.legal) |=> (mode_err && !col_valid));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !advance && !start && !abort) |=> (col_valid && $stable(col_addr)));

  generate
    if (COL_W > BEAT_W) begin : g_blk_chk
      p_block_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !start && !abort) |=>
          (!col_valid || col_addr[COL_W-1:BEAT_W] == $past(col_addr[COL_W-1:BEAT_W])));
    end
  endgenerate

endmodule

// File: tb/burst_colgen_test.sv
module burst_colgen_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, order_sel, advance, abort;
  logic [8:0] start_col;
  logic [2:0] len_code;
  logic [8:0] col_addr;
  logic       col_valid, col_last, mode_err;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [8:0] col;
    bit         last;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .order_sel(order_sel), .advance(advance), .abort(abort),
    .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last), .mode_err(mode_err)
  );

  function automatic int code_lg(input logic [2:0] c);
    case (c)
      3'b001:  return 1;
      3'b010:  return 2;
      3'b011:  return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [8:0] exp_col(input logic [8:0] c, input int lg, input bit il, input int k);
    int n, so, off;
    n   = 1 << lg;
    so  = int'(c) & (n - 1);
    off = il ? (so ^ k) : ((so + k) % n);
    return 9'((int'(c) & ~(n - 1)) | off);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compares each presented beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && col_valid) begin
      vectors++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R6 R8 R9: actual valid beat col %0h expected no beat at %0t", col_addr, $time);
      end else begin
        if (col_addr !== q[0].col || col_last !== q[0].last) begin
          fails++;
          $display("FAIL %s: actual col %0h last %0b expected col %0h last %0b at %0t",
                   q[0].tag, col_addr, col_last, q[0].col, q[0].last, $time);
        end
        if (advance) void'(q.pop_front());
      end
    end
  end

  // driver: issue a start strobe and load the expected beats
  task automatic do_start(input logic [8:0] c, input logic [2:0] code, input bit il, input string tag);
    int lg;
    start = 1'b1; start_col = c; len_code = code; order_sel = il; advance = 1'b0;
    @(negedge clk); #1;
    q.delete();
    lg = code_lg(code);
    if (lg != 0) begin
      for (int k = 0; k < (1 << lg); k++) begin
        exp_t e;
        e.col  = exp_col(c, lg, il, k);
        e.last = (k == (1 << lg) - 1);
        e.tag  = tag;
        q.push_back(e);
      end
    end
    @(posedge clk); #1;
    start = 1'b0;
    // R11: disturb the mode inputs after the strobe
    start_col = ~c; len_code = ~code; order_sel = ~il;
  endtask

  task automatic run_beats(input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall) begin
        advance = 1'b0;
        @(posedge clk); #1;
      end
      advance = 1'b1;
      @(posedge clk); #1;
    end
    advance = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [8:0] cols [5];
    cols = '{9'h000, 9'h1FF, 9'h105, 9'h0AA, 9'h0F3};
    rst_n = 1'b0; start = 1'b0; start_col = '0; len_code = 3'b001;
    order_sel = 1'b0; advance = 1'b0; abort = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 valid", {31'd0, col_valid}, 0);
    check("R1 last",  {31'd0, col_last},  0);
    check("R1 err",   {31'd0, mode_err},  0);

    // R2 R3 R4 R5 R6 R7 R11: all lengths and orderings
    for (int code = 1; code <= 3; code++) begin
      for (int il = 0; il <= 1; il++) begin
        for (int ci = 0; ci < 5; ci++) begin
          do_start(cols[ci], 3'(code), il[0], il ? "R4 R5 interleaved" : "R3 R5 sequential");
          run_beats(1 << code, ci[0]);
          check("R7 valid drops after last", {31'd0, col_valid}, 0);
          check("R2 beat count", q.size(), 0);
        end
      end
    end

    // R3 and R4 worked examples
    do_start(9'h041, 3'b010, 1'b0, "R3 len4 start1");
    run_beats(4, 1'b0);
    do_start(9'h0C5, 3'b011, 1'b1, "R4 len8 start5");
    run_beats(8, 1'b1);

    // R8 reserved codes
    for (int rc = 0; rc < 8; rc++) begin
      if (rc == 0 || rc >= 4) begin
        do_start(9'h012, 3'(rc), 1'b0, "R8 reserved");
        check("R8 err set", {31'd0, mode_err}, 1);
        check("R8 no beat", {31'd0, col_valid}, 0);
        run_beats(3, 1'b0);
        check("R8 err sticky", {31'd0, mode_err}, 1);
      end
    end
    do_start(9'h013, 3'b001, 1'b0, "R8 legal after reserved");
    check("R8 err cleared", {31'd0, mode_err}, 0);
    run_beats(2, 1'b0);

    // R9 abort mid burst with a simultaneous start
    do_start(9'h158, 3'b011, 1'b0, "R9 pre-abort");
    run_beats(2, 1'b0);
    abort = 1'b1; start = 1'b1; start_col = 9'h001; len_code = 3'b011;
    @(negedge clk); #1 q.delete();
    @(posedge clk); #1 abort = 1'b0; start = 1'b0;
    check("R9 valid cleared", {31'd0, col_valid}, 0);
    run_beats(2, 1'b0);
    check("R9 stays idle", {31'd0, col_valid}, 0);

    // R10 restart during a burst
    do_start(9'h0E6, 3'b010, 1'b0, "R10 first");
    run_beats(1, 1'b0);
    do_start(9'h137, 3'b011, 1'b1, "R10 restarted");
    run_beats(8, 1'b0);
    check("R10 ends", {31'd0, col_valid}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule